// File: doc/BRIEF.md
# Symbol-Pattern Triggered Raw Word Capture

This block watches one serial lane after line decoding. Each clock cycle it receives two decoded 8b/10b symbols, with a flag per symbol that marks a control (K) character, and beside them the 20-bit raw word those two symbols came from, still in line code. A programmable pattern picks the symbols that fire the trigger. Each symbol position has its own enable, and the K flag must match as well as the byte value.

Once software arms the engine, the first valid word that matches the pattern fires a one-cycle trigger pulse. The engine then stores raw words into an on-chip buffer: the matching word first, then the valid words that follow it, until the buffer is full. The record stays frozen until the engine is armed again. A host reads the buffer back one word at a time by presenting an address. The data appears one cycle later.

Top module: `symtrig_capture`

## Requirements
- R1: After reset `state_o` is IDLE (encoding IDLE=0, ARMED=1, CAPTURING=2, DONE=3) and `trig_pulse` is low.
- R2: `arm` sampled high in IDLE or DONE moves the engine to ARMED on the next edge. No word triggers the engine while it is in IDLE.
- R3: Symbol lane i occupies `dec_data[8*i+7:8*i]`, with its K flag in `dec_k[i]`; lane 0 is the low byte. A lane takes part in the match when `byte_en[i]`=1, and it matches when both its byte equals `pat_data[8*i+7:8*i]` and `dec_k[i]` equals `pat_k[i]`. A valid word triggers the engine when every enabled lane matches. With `byte_en` all zero, any valid word triggers it.
- R4: A lane that carries the pattern byte with the wrong K flag does not match, whichever way the flag differs.
- R5: `trig_pulse` is high for exactly one cycle, starting at the edge that samples the matching word in ARMED. On that same edge the state becomes CAPTURING.
- R6: The raw word of the triggering cycle is stored at address 0. Each later cycle with `in_valid`=1 stores its raw word at the next address. Cycles with `in_valid`=0 store nothing.
- R7: The edge that stores the word at address DEPTH-1 moves the state to DONE. In DONE, incoming words change nothing in the buffer.
- R8: `rd_data` presents the buffer word at `rd_addr` one cycle after the address is sampled.
- R9: `arm` during CAPTURING is ignored. Arming from DONE starts a new record that overwrites the buffer from address 0.
- R10: Words that match the pattern during CAPTURING or DONE raise no trigger pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm command, sampled per cycle |
| byte_en | input | LANES | Per-lane match enable |
| pat_data | input | 8*LANES | Pattern bytes |
| pat_k | input | LANES | Pattern K flags |
| in_valid | input | 1 | Raw and decoded inputs carry a word this cycle |
| raw_word | input | RAW_W | Raw line-coded word |
| dec_data | input | 8*LANES | Decoded bytes |
| dec_k | input | LANES | Decoded K flags |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| state_o | output | 2 | Engine state |
| rd_addr | input | clog2(DEPTH) | Readout address |
| rd_data | output | RAW_W | Readout data, one cycle latency |

## Verification
The bench sends the pattern byte with the K flag cleared and with both flags set. A design that ignored the K flag would trigger on a plain data byte. It sends matching words before arming, while capturing and after the buffer is full. A design that judged the state wrongly would pulse twice or overwrite the frozen record, and the readout would show it. Gaps in `in_valid` sit inside the capture, so a design that stored on idle cycles would shift every later address. The bench also asserts `arm` during capture and checks that the record is not restarted, and it uses a single-lane enable and an all-zero enable to show that only enabled lanes are compared.

// File: rtl/symtrig_capture.sv
module symtrig_capture #(
  parameter int DEPTH = 16,
  parameter int RAW_W = 20,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [LANES-1:0] byte_en,
  input  logic [DW-1:0]    pat_data,
  input  logic [LANES-1:0] pat_k,
  input  logic             in_valid,
  input  logic [RAW_W-1:0] raw_word,
  input  logic [DW-1:0]    dec_data,
  input  logic [LANES-1:0] dec_k,
  output logic             trig_pulse,
  output logic [1:0]       state_o,
  input  logic [AW-1:0]    rd_addr,
  output logic [RAW_W-1:0] rd_data
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ARMED = 2'd1, S_CAP = 2'd2, S_DONE = 2'd3} st_t;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  st_t              st;
  logic [AW-1:0]    wr_ptr;
  logic [LANES-1:0] lane_hit;
  logic             hit, we;
  logic [AW-1:0]    waddr;
  logic [RAW_W-1:0] buf_q [DEPTH];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_hit[i] = !byte_en[i] ||
      ((dec_data[8*i +: 8] == pat_data[8*i +: 8]) && (dec_k[i] == pat_k[i]));
  end

  assign hit     = in_valid && (&lane_hit);
  assign we      = (st == S_ARMED && hit) || (st == S_CAP && in_valid);
  assign waddr   = (st == S_ARMED) ? '0 : wr_ptr;
  assign state_o = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wr_ptr     <= '0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= 1'b0;
      case (st)
        S_IDLE:  if (arm) st <= S_ARMED;
        S_ARMED: if (hit) begin
          st         <= S_CAP;
          wr_ptr     <= AW'(1);
          trig_pulse <= 1'b1;
        end
        S_CAP:   if (in_valid) begin
          wr_ptr <= wr_ptr + AW'(1);
          if (wr_ptr == LAST) st <= S_DONE;
        end
        S_DONE:  if (arm) st <= S_ARMED;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (we) buf_q[waddr] <= raw_word;
    rd_data <= buf_q[rd_addr];
  end

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
  assert_pulse_from_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> ($past(st) == S_ARMED && st == S_CAP));
  assert_idle_no_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> (st != S_CAP && !trig_pulse));
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !arm) |=> (st == S_DONE));
  assert_last_word_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAP && in_valid && wr_ptr == LAST) |=> (st == S_DONE));
  assert_gap_holds_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAP && !in_valid) |=> ($stable(wr_ptr) && st == S_CAP));
  assert_arm_ignored_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAP && arm) |=> (st != S_ARMED));
endmodule

// File: tb/symtrig_capture_tb_top.sv
`timescale 1ns/1ps
module symtrig_capture_tb_top;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [1:0] byte_en = 2'b11;
  logic [15:0] pat_data = 16'h50BC;
  logic [1:0] pat_k = 2'b01;
  logic in_valid = 1'b0;
  logic [19:0] raw_word = '0;
  logic [15:0] dec_data = '0;
  logic [1:0] dec_k = '0;
  logic trig_pulse;
  logic [1:0] state_o;
  logic [AW-1:0] rd_addr = '0;
  logic [19:0] rd_data;

  int checks = 0;
  int fails = 0;
  logic [19:0] exp_buf [DEPTH];

  always #2 clk = ~clk;

  symtrig_capture #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .byte_en(byte_en), .pat_data(pat_data),
    .pat_k(pat_k), .in_valid(in_valid), .raw_word(raw_word), .dec_data(dec_data),
    .dec_k(dec_k), .trig_pulse(trig_pulse), .state_o(state_o), .rd_addr(rd_addr),
    .rd_data(rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic v, input logic [15:0] d,
                      input logic [1:0] k, input logic [19:0] r);
    @(negedge clk);
    arm = a; in_valid = v; dec_data = d; dec_k = k; raw_word = r;
    @(posedge clk); #1;
    @(negedge clk);
    arm = 1'b0; in_valid = 1'b0;
  endtask

  task automatic rd(input int a, output logic [19:0] q);
    @(negedge clk);
    rd_addr = AW'(a);
    @(posedge clk); #1;
    q = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk("R1 state after reset", state_o, 0);
    chk("R1 pulse after reset", trig_pulse, 0);
    step(0, 1, 16'h50BC, 2'b01, 20'h11111);
    chk("R2 match in IDLE ignored state", state_o, 0);
    chk("R2 match in IDLE no pulse", trig_pulse, 0);
    step(1, 0, 0, 0, 0);
    chk("R2 arm from IDLE", state_o, 1);
  endtask

  task automatic t_k_mismatch();
    step(0, 1, 16'h50BC, 2'b00, 20'h22222);
    chk("R4 K flag clear no match", state_o, 1);
    step(0, 1, 16'h50BC, 2'b11, 20'h22223);
    chk("R4 K flag extra no match", state_o, 1);
    step(0, 1, 16'h51BC, 2'b01, 20'h22224);
    chk("R3 high byte differs no match", trig_pulse, 0);
    step(0, 0, 16'h50BC, 2'b01, 20'h22225);
    chk("R3 invalid word no match", state_o, 1);
  endtask

  task automatic t_full_capture();
    logic [19:0] q;
    step(0, 1, 16'h50BC, 2'b01, 20'hC0000);
    exp_buf[0] = 20'hC0000;
    chk("R5 pulse on match", trig_pulse, 1);
    chk("R5 state capturing", state_o, 2);
    step(0, 0, 0, 0, 20'hDEAD0);
    chk("R5 pulse one cycle", trig_pulse, 0);
    for (int i = 1; i < DEPTH; i++) begin
      if (i == 5) step(0, 0, 0, 0, 20'hBAD00);
      exp_buf[i] = 20'hC0000 + 20'(i * 7);
      step(i == 3, 1, (i == 3) ? 16'h50BC : 16'h0000, (i == 3) ? 2'b01 : 2'b00, exp_buf[i]);
      if (i == 3) begin
        chk("R10 match during capture no pulse", trig_pulse, 0);
        chk("R9 arm during capture ignored", state_o, 2);
      end
      if (i < DEPTH - 1) chk("R7 still capturing", state_o, 2);
    end
    chk("R7 done after last word", state_o, 3);
    for (int j = 0; j < 3; j++) begin
      step(0, 1, 16'h50BC, 2'b01, 20'hFFFFF);
      chk("R10 match in DONE no pulse", trig_pulse, 0);
    end
    chk("R7 stays done", state_o, 3);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, q);
      chk($sformatf("R6 R8 readout addr %0d", a), q, exp_buf[a]);
    end
  endtask

  task automatic t_rearm_lane_mask();
    logic [19:0] q;
    byte_en = 2'b10; pat_data = 16'h3C00; pat_k = 2'b10;
    step(1, 0, 0, 0, 0);
    chk("R9 rearm from DONE", state_o, 1);
    step(0, 1, 16'h3D00, 2'b10, 20'h33330);
    chk("R3 enabled lane differs", state_o, 1);
    step(0, 1, 16'h3C77, 2'b10, 20'h33331);
    chk("R3 disabled lane ignored trigger", trig_pulse, 1);
    rd(0, q);
    chk("R9 new record at addr 0", q, 20'h33331);
    rd(1, q);
    chk("R9 addr 1 untouched yet", q, exp_buf[1]);
  endtask

  task automatic t_any_word();
    logic [19:0] q;
    do_reset();
    byte_en = 2'b00;
    step(1, 0, 0, 0, 0);
    step(0, 1, 16'h1234, 2'b11, 20'h44444);
    chk("R3 empty enable any word triggers", trig_pulse, 1);
    rd(0, q);
    chk("R6 trigger word stored", q, 20'h44444);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_k_mismatch();
    t_full_capture();
    t_rearm_lane_mask();
    t_any_word();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule